// File: doc/BRIEF.md
# Auto-Negotiation Arbitration Controller

This block is the arbitration state machine of a 10/100 Ethernet PHY's link negotiation. It decides when a negotiation round begins. It supplies the 16-bit link code word that a separate burst encoder sends, and it takes in the words that the matching burst decoder recovers from the partner. From these it selects the best speed and duplex mode that both ends support. It then completes an acknowledge handshake and reports the chosen mode.

Several events start a round: synchronous reset followed by an enabled cycle, an explicit restart pulse, any pulse on a small vector of system events, a falling link indication, and the enable control going high. Timeout, content change and the handshake itself are handled inside the block. The advertisement input is captured only when a round begins, so changing it has no effect until the next start.

Top module: `autoneg_arbiter`

## Requirements
- R1: While `rst` is high, `tx_en`, `an_done`, `res_valid` and `res_fault` are 0. In the first cycle after `rst` falls with `an_enable` high, a round begins and `tx_en` goes to 1.
- R2: A round begins one clock after any of these, while enabled: `restart_req` high, any bit of `evt_i` high, `link_up` falling from 1 to 0, or `an_enable` rising. On entry `tx_word[14]` is 0, `an_done` and `res_valid` are 0, and `adv_abil` is captured.
- R3: While `an_enable` is low, the block is idle: `tx_en` and `an_done` are 0 from the next cycle on, and start events are ignored.
- R4: `tx_word` carries selector 5'b00001 in bits [4:0] and the captured abilities in bits [8:5], ordered {100 full, 100 half, 10 full, 10 half} from bit 8 down to bit 5. Bit 14 is the acknowledge flag. Every other bit is 0.
- R5: A partner word is taken as matched only after three consecutive received words (`rx_valid` pulses) that are equal apart from bit 14 and that carry selector 5'b00001. A word with a different content or a wrong selector starts the count again.
- R6: On a match, the mode is the highest common ability, ranked 100 full > 100 half > 10 full > 10 half. `res_mode` encodes these as 3, 2, 1 and 0.
- R7: If the match has no common ability, `res_fault` pulses for one cycle and the block keeps seeking abilities, with `tx_word[14]` left at 0.
- R8: After a match, `tx_word[14]` is 1. Three received words with bit 14 set and the matched content lead, two clocks after the third, to the link-good state: `an_done` = 1, `res_valid` = 1 and `tx_en` = 0.
- R9: During acknowledgement, a received word whose content (excluding bit 14) differs from the matched one restarts the round (`tx_word[14]` returns to 0).
- R10: While seeking abilities or acknowledging, `TMO_CYC` clock cycles without an `rx_valid` restart the round, which re-captures `adv_abil`.
- R11: Changing `adv_abil` alone changes neither `tx_word` nor the result until the next round begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| an_enable | input | 1 | Negotiation enable control |
| restart_req | input | 1 | Restart request pulse |
| evt_i | input | NUM_EVT | System event pulses (soft reset, power-down exit, digital reset, reload) |
| link_up | input | 1 | Link status; a falling edge restarts |
| adv_abil | input | 4 | Abilities to advertise {100F,100H,10F,10H} |
| tx_word | output | 16 | Link code word for the burst encoder |
| tx_en | output | 1 | Burst transmission active |
| rx_word | input | 16 | Word recovered from the partner's burst |
| rx_valid | input | 1 | One-cycle strobe for `rx_word` |
| res_mode | output | 2 | Resolved mode (3=100F, 2=100H, 1=10F, 0=10H) |
| res_valid | output | 1 | `res_mode` holds a completed result |
| an_done | output | 1 | Negotiation complete, link good |
| res_fault | output | 1 | One-cycle pulse: no common ability |

## Verification
Random pairs of local and partner ability sets check the priority choice against a bench model. Pairs with no common ability separate the fault path from a real resolution. Directed word sequences check the match count: one sequence interleaves differing words, another has a broken selector, so a block that counts non-consecutive or malformed words would finish early. Further directed cases remove the partner's words, change their content during acknowledgement, rewrite the advertisement without a restart, and fire each start event in turn. Together these show which trigger, and only that trigger, re-enters negotiation.

// File: rtl/autoneg_pkg.sv
package autoneg_pkg;
  typedef enum logic [2:0] {
    AN_OFF,
    AN_ABIL,
    AN_ACKW,
    AN_CPL,
    AN_GOOD
  } an_state_e;

  localparam int WORD_W   = 16;
  localparam int ABIL_N   = 4;
  localparam int ABIL_LO  = 5;
  localparam int ACK_BIT  = 14;
  localparam logic [4:0] SEL_IEEE = 5'b00001;
  localparam logic [WORD_W-1:0] ACK_MASK = WORD_W'(1) << ACK_BIT;
endpackage

// File: rtl/an_start_detect.sv
module an_start_detect #(
  parameter int NUM_EVT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               an_enable,
  input  logic               restart_req,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               link_up,
  output logic               start_o
);
  logic link_q, en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      link_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      link_q <= link_up;
      en_q   <= an_enable;
    end
  end

  assign start_o = restart_req | (|evt_i) | (link_q & ~link_up) | (an_enable & ~en_q);
endmodule

// File: rtl/an_burst_timer.sv
module an_burst_timer #(
  parameter int TMO_CYC = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic kick_i,
  output logic expired_o
);
  localparam int CW = $clog2(TMO_CYC + 1);
  logic [CW-1:0] cnt_q;

  assign expired_o = run_i && !kick_i && (cnt_q == CW'(TMO_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || !run_i || kick_i || expired_o) cnt_q <= '0;
    else                                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/an_prio_resolve.sv
module an_prio_resolve #(
  parameter int N  = 4,
  localparam int MW = $clog2(N)
) (
  input  logic [N-1:0]  common_i,
  output logic          any_o,
  output logic [MW-1:0] mode_o
);
  always_comb begin
    mode_o = '0;
    for (int i = 0; i < N; i++) begin
      if (common_i[i]) mode_o = MW'(i);
    end
  end

  assign any_o = |common_i;
endmodule

// File: rtl/autoneg_arbiter.sv
module autoneg_arbiter
  import autoneg_pkg::*;
#(
  parameter int NUM_EVT = 4,
  parameter int MATCH_N = 3,
  parameter int ACK_N   = 3,
  parameter int TMO_CYC = 50000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               an_enable,
  input  logic               restart_req,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               link_up,
  input  logic [3:0]         adv_abil,
  output logic [15:0]        tx_word,
  output logic               tx_en,
  input  logic [15:0]        rx_word,
  input  logic               rx_valid,
  output logic [1:0]         res_mode,
  output logic               res_valid,
  output logic               an_done,
  output logic               res_fault
);
  localparam int MW = $clog2(MATCH_N + 1);
  localparam int AW = $clog2(ACK_N + 1);

  an_state_e         state_q;
  logic [ABIL_N-1:0] adv_q;
  logic [WORD_W-1:0] last_q;
  logic [MW-1:0]     mcnt_q;
  logic [AW-1:0]     acnt_q;
  logic [1:0]        mode_q;
  logic              valid_q, done_q, fault_q;

  logic start, tmo, run, any_common;
  logic [1:0] new_mode;
  logic [WORD_W-1:0] rx_content;
  logic [ABIL_N-1:0] common;
  logic rx_sel_ok;

  assign rx_content = rx_word & ~ACK_MASK;
  assign rx_sel_ok  = (rx_word[4:0] == SEL_IEEE);
  assign common     = adv_q & rx_word[ABIL_LO +: ABIL_N];
  assign run        = (state_q == AN_ABIL) || (state_q == AN_ACKW);

  an_start_detect #(.NUM_EVT(NUM_EVT)) u_start (
    .clk(clk), .rst(rst), .an_enable(an_enable), .restart_req(restart_req),
    .evt_i(evt_i), .link_up(link_up), .start_o(start)
  );

  an_burst_timer #(.TMO_CYC(TMO_CYC)) u_timer (
    .clk(clk), .rst(rst), .run_i(run), .kick_i(rx_valid | start), .expired_o(tmo)
  );

  an_prio_resolve #(.N(ABIL_N)) u_prio (
    .common_i(common), .any_o(any_common), .mode_o(new_mode)
  );

  always_ff @(posedge clk) begin
    fault_q <= 1'b0;
    if (rst) begin
      state_q <= AN_OFF;
      adv_q   <= '0;
      last_q  <= '0;
      mcnt_q  <= '0;
      acnt_q  <= '0;
      mode_q  <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (!an_enable) begin
      state_q <= AN_OFF;
      mcnt_q  <= '0;
      acnt_q  <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (start || tmo) begin
      state_q <= AN_ABIL;
      adv_q   <= adv_abil;
      mcnt_q  <= '0;
      acnt_q  <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      unique case (state_q)
        AN_ABIL: if (rx_valid) begin
          if (!rx_sel_ok) begin
            mcnt_q <= '0;
          end else if (mcnt_q == '0 || rx_content != last_q) begin
            last_q <= rx_content;
            mcnt_q <= MW'(1);
          end else if (mcnt_q == MW'(MATCH_N - 1)) begin
            mcnt_q <= '0;
            if (any_common) begin
              mode_q  <= new_mode;
              acnt_q  <= '0;
              state_q <= AN_ACKW;
            end else begin
              fault_q <= 1'b1;
            end
          end else begin
            mcnt_q <= mcnt_q + 1'b1;
          end
        end
        AN_ACKW: if (rx_valid) begin
          if (rx_content != last_q) begin
            state_q <= AN_ABIL;
            adv_q   <= adv_abil;
            mcnt_q  <= '0;
            acnt_q  <= '0;
          end else if (rx_word[ACK_BIT]) begin
            if (acnt_q == AW'(ACK_N - 1)) state_q <= AN_CPL;
            else                          acnt_q  <= acnt_q + 1'b1;
          end
        end
        AN_CPL: begin
          state_q <= AN_GOOD;
          valid_q <= 1'b1;
          done_q  <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign tx_en     = (state_q == AN_ABIL) || (state_q == AN_ACKW) || (state_q == AN_CPL);
  assign tx_word   = {1'b0, (state_q == AN_ACKW) || (state_q == AN_CPL), 5'b0, adv_q, SEL_IEEE};
  assign res_mode  = mode_q;
  assign res_valid = valid_q;
  assign an_done   = done_q;
  assign res_fault = fault_q;
endmodule

// File: rtl/autoneg_arbiter_chk.sv
module autoneg_arbiter_chk (
  input logic        clk,
  input logic        rst,
  input logic        an_enable,
  input logic [15:0] tx_word,
  input logic        tx_en,
  input logic        an_done,
  input logic        res_fault
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!tx_en && !an_done && !res_fault));

  // R3
  disabled_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !an_enable |=> (!tx_en && !an_done));

  // R4
  word_format_chk: assert property (@(posedge clk) disable iff (rst)
    tx_en |-> (tx_word[4:0] == 5'b00001 && tx_word[15] == 1'b0 && tx_word[13:9] == 5'b0));

  // R7
  fault_no_ack_chk: assert property (@(posedge clk) disable iff (rst)
    res_fault |-> (!tx_word[14] && !an_done));

  // R8
  done_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(an_done) |-> $past(tx_word[14]));

  // R11
  adv_stable_ack_chk: assert property (@(posedge clk) disable iff (rst)
    tx_word[14] |-> $stable(tx_word[8:5]));
endmodule

bind autoneg_arbiter autoneg_arbiter_chk u_chk (.*);

// File: tb/tb_autoneg_arbiter.sv
`timescale 1ns/100ps
module tb_autoneg_arbiter;
  localparam int NEV = 4;
  localparam int TMO = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic an_enable = 1'b1, restart_req = 1'b0, link_up = 1'b1, rx_valid = 1'b0;
  logic [NEV-1:0] evt_i = '0;
  logic [3:0] adv_abil = 4'hF;
  logic [15:0] rx_word = '0, tx_word;
  logic tx_en, res_valid, an_done, res_fault;
  logic [1:0] res_mode;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  autoneg_arbiter #(.NUM_EVT(NEV), .MATCH_N(3), .ACK_N(3), .TMO_CYC(TMO)) dut (
    .clk(clk), .rst(rst), .an_enable(an_enable), .restart_req(restart_req), .evt_i(evt_i),
    .link_up(link_up), .adv_abil(adv_abil), .tx_word(tx_word), .tx_en(tx_en),
    .rx_word(rx_word), .rx_valid(rx_valid), .res_mode(res_mode), .res_valid(res_valid),
    .an_done(an_done), .res_fault(res_fault)
  );

  function automatic logic [15:0] pw(input logic [3:0] ab, input logic ack);
    return {1'b0, ack, 5'b0, ab, 5'b00001};
  endfunction

  function automatic int exp_mode(input logic [3:0] c);
    for (int i = 3; i >= 0; i--) if (c[i]) return i;
    return -1;
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_rx(input logic [15:0] w, output logic flt);
    rx_word = w; rx_valid = 1'b1;
    tick();
    flt = res_fault;
    rx_valid = 1'b0;
    tick();
  endtask

  task automatic pulse_restart();
    restart_req = 1'b1; tick(); restart_req = 1'b0;
  endtask

  // full round from a restart; returns with the block in link-good when a common mode exists
  task automatic full_neg(input logic [3:0] adv, input logic [3:0] par);
    logic f;
    logic [3:0] c;
    adv_abil = adv;
    pulse_restart();
    chk(tx_word[8:5] == adv && tx_word[4:0] == 5'b00001, "R4 word", tx_word, pw(adv, 1'b0));
    for (int k = 0; k < 3; k++) send_rx(pw(par, 1'b0), f);
    c = adv & par;
    if (c == 4'b0) begin
      chk(tx_word[14] == 1'b0, "R7 no ack on fault", tx_word[14], 0);
      chk(f == 1'b1, "R7 fault pulse", f, 1);
    end else begin
      chk(f == 1'b0 && tx_word[14] == 1'b1, "R8 ack set", tx_word[14], 1);
      for (int k = 0; k < 3; k++) send_rx(pw(par, 1'b1), f);
      chk(an_done && res_valid && !tx_en, "R8 done", {an_done, res_valid, tx_en}, 3'b110);
      chk(int'(res_mode) == exp_mode(c), "R6 mode", res_mode, exp_mode(c));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic f;
    void'($urandom(32'h5eed));
    // R1 reset
    tick(); tick();
    chk(!tx_en && !an_done && !res_valid && !res_fault, "R1 reset quiet", tx_en, 0);
    rst = 1'b0;
    tick();
    chk(tx_en == 1'b1 && tx_word[14] == 1'b0, "R1 start after reset", tx_en, 1);
    chk(tx_word[8:5] == 4'hF, "R4 adv captured", tx_word[8:5], 15);

    // random pairs
    for (int it = 0; it < 24; it++) begin
      logic [3:0] a, p;
      a = 4'($urandom_range(1, 15));
      p = 4'($urandom_range(0, 15));
      full_neg(a, p);
    end

    // R5 non-consecutive and bad selector
    adv_abil = 4'b0011;
    pulse_restart();
    send_rx(pw(4'b0001, 1'b0), f);
    send_rx(pw(4'b0001, 1'b0), f);
    send_rx(pw(4'b0010, 1'b0), f);
    send_rx(pw(4'b0010, 1'b0), f);
    chk(tx_word[14] == 1'b0, "R5 interleaved not matched", tx_word[14], 0);
    send_rx(pw(4'b0010, 1'b0), f);
    chk(tx_word[14] == 1'b1 && res_mode == 2'd1, "R5 R6 match after 3 equal", res_mode, 1);
    pulse_restart();
    send_rx(pw(4'b0001, 1'b0), f);
    send_rx(pw(4'b0001, 1'b0), f);
    send_rx(pw(4'b0001, 1'b0) ^ 16'h0003, f);
    send_rx(pw(4'b0001, 1'b0), f);
    send_rx(pw(4'b0001, 1'b0), f);
    chk(tx_word[14] == 1'b0, "R5 bad selector breaks chain", tx_word[14], 0);
    send_rx(pw(4'b0001, 1'b0), f);
    chk(tx_word[14] == 1'b1 && res_mode == 2'd0, "R5 match after chain", res_mode, 0);

    // R9 content change during ack
    send_rx(pw(4'b0011, 1'b1), f);
    chk(tx_word[14] == 1'b0 && tx_en, "R9 change restarts", tx_word[14], 0);

    // R10 timeout during ack
    full_neg(4'b1111, 4'b1111);
    pulse_restart();
    for (int k = 0; k < 3; k++) send_rx(pw(4'b0100, 1'b0), f);
    chk(tx_word[14] == 1'b1, "R10 pre ack", tx_word[14], 1);
    repeat (TMO + 5) tick();
    chk(tx_word[14] == 1'b0 && tx_en, "R10 ack timeout", tx_word[14], 0);

    // R11 + R10 adv change in seek state, then timeout re-captures
    adv_abil = 4'b1000;
    pulse_restart();
    adv_abil = 4'b0101;
    repeat (10) tick();
    chk(tx_word[8:5] == 4'b1000, "R11 adv not applied", tx_word[8:5], 8);
    repeat (TMO) tick();
    chk(tx_word[8:5] == 4'b0101, "R10 timeout recapture", tx_word[8:5], 5);

    // R11 in link-good
    full_neg(4'b0110, 4'b0010);
    adv_abil = 4'b1001;
    repeat (5) tick();
    chk(an_done && res_mode == 2'd1 && tx_word[8:5] == 4'b0110, "R11 no effect when done", tx_word[8:5], 6);

    // R2 each event bit
    for (int b = 0; b < NEV; b++) begin
      full_neg(4'b1100, 4'b0100);
      evt_i[b] = 1'b1; tick(); evt_i = '0;
      chk(!an_done && tx_en && tx_word[14] == 1'b0, "R2 event restart", an_done, 0);
    end

    // R2 link drop
    full_neg(4'b1010, 4'b1010);
    link_up = 1'b0; tick();
    chk(!an_done && !res_valid && tx_en, "R2 link fall restart", an_done, 0);
    link_up = 1'b1;

    // R3 disable
    full_neg(4'b1111, 4'b0001);
    an_enable = 1'b0; tick();
    chk(!tx_en && !an_done, "R3 disabled", tx_en, 0);
    pulse_restart();
    evt_i = '1; tick(); evt_i = '0; tick();
    chk(!tx_en && !an_done, "R3 events ignored", tx_en, 0);
    adv_abil = 4'b0010;
    an_enable = 1'b1; tick();
    chk(tx_en && tx_word[8:5] == 4'b0010 && !tx_word[14], "R2 enable rise start", tx_word[8:5], 2);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule